// File: doc/BRIEF.md
# Operand Bypass and Interlock Controller

This block decides, for a three-stage in-order pipeline (fetch/decode, then read/execute/memory, then writeback), whether the instruction now in decode can take its source operands from the normal register read path, whether it needs the writeback result steered in through a bypass, or whether it must wait. The controller follows the instruction ahead of decode in a small slot state machine. That instruction's destination, write flag and load flag are captured as it leaves decode. Each source of the decoding instruction is compared against that slot.

A build parameter `NUM_FWD` sets how many bypass paths exist. With two paths, both source operands can be bypassed. With one path, only operand A has a bypass, and a match on operand B costs one stall cycle. A load result can never be bypassed to the very next instruction, so a load followed by a consumer always interlocks for one cycle, whatever the setting. Branches are predicted not taken. When a branch resolves taken in the execute stage, the wrongly fetched instruction in decode is flushed, and the flush takes precedence over any interlock.

The slot state machine has four states. `SLOT_BUBBLE`: the slot holds a no-op. `SLOT_NOWRITE`: a valid instruction that writes no register, or writes register 0. `SLOT_ALU`: a register writer whose result can be bypassed. `SLOT_LOAD`: a load writing a register. On every clock the slot takes one of four transitions. `T_TAKE_BUBBLE` is used on stall, flush or an invalid decode. `T_TAKE_QUIET` is used for an advancing non-writer. `T_TAKE_ALU` and `T_TAKE_LOAD` are used for advancing writers.

Top module: `fwd_interlock`

## Requirements
- R1: While `rst_n` is low, and after it is released, `fwd_a`, `fwd_b` and `stall` are 0 and the slot is empty. A consumer decoded with no prior producer does not stall.
- R2: Register number 0 never counts as a dependence. A producer writing register 0 causes no stall and no bypass.
- R3: With `NUM_FWD`=2, a consumer that reads the destination of the preceding non-load writer never stalls. In the cycle after the consumer leaves decode, `fwd_a` (resp. `fwd_b`) is 1 exactly when operand A (resp. B) matched.
- R4: With `NUM_FWD`=1, a match on operand A alone does not stall, and `fwd_a` is 1 in the following cycle. `fwd_b` is never 1 in this configuration.
- R5: With `NUM_FWD`=1, a match on operand B, alone or together with operand A, against a non-load writer holds `stall` high for exactly one cycle. When the consumer then advances, both bypass selects are 0.
- R6: A consumer that reads the destination of the immediately preceding load stalls for exactly one cycle under either setting, and no bypass select is raised for it.
- R7: `bubble` is 1 in every cycle in which `stall` is 1. `stall` is never high in two consecutive cycles.
- R8: When `br_taken` is 1, `flush` and `bubble` are 1 and `stall` is 0. In the next cycle both bypass selects are 0 and the slot is empty.
- R9: A source whose read enable is 0, a producer whose write flag is 0, or a cycle with `dec_valid` at 0 creates no dependence: no stall, and no bypass select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| dec_src_a | input | REG_W | Source register of operand A |
| dec_rd_a | input | 1 | Operand A is read from the register file |
| dec_src_b | input | REG_W | Source register of operand B |
| dec_rd_b | input | 1 | Operand B is read from the register file |
| dec_dst | input | REG_W | Destination register of the decoding instruction |
| dec_wr | input | 1 | Decoding instruction writes its destination |
| dec_load | input | 1 | Decoding instruction is a load |
| br_taken | input | 1 | Branch in execute resolved taken this cycle |
| fwd_a | output | 1 | Operand A of the instruction in execute takes the writeback result |
| fwd_b | output | 1 | Operand B of the instruction in execute takes the writeback result |
| stall | output | 1 | Hold the PC and the decode register this cycle |
| bubble | output | 1 | Load a no-op into execute at the next edge |
| flush | output | 1 | Discard the instruction in decode |

## Verification
`stall`, `bubble` and `flush` are combinational and are read 1 time unit after the falling edge at which the decode inputs change, in the same cycle. The bypass selects are registered. They belong to the cycle after the consumer leaves decode, so the bench reads them just after the falling edge that follows the last rising edge with `stall` low. Every producer/consumer pair starts from an empty slot, and stall cycles are counted by re-sampling after each falling edge while the consumer is held. This gives the stall count exactly, without cycle aliasing from neighbouring pairs.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    typedef enum logic [1:0] {
        SLOT_BUBBLE  = 2'd0,
        SLOT_NOWRITE = 2'd1,
        SLOT_ALU     = 2'd2,
        SLOT_LOAD    = 2'd3
    } slot_state_t;

    localparam int OPERANDS = 2;
    localparam int OP_A     = 0;
    localparam int OP_B     = 1;

endpackage

// File: rtl/hzd_slot_fsm.sv
module hzd_slot_fsm
    import hzd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [REG_W-1:0] dec_dst,
    input  logic             dec_wr,
    input  logic             dec_load,
    output slot_state_t      slot_state,
    output logic [REG_W-1:0] slot_dst,
    output logic             slot_live,
    output logic             slot_alu,
    output logic             slot_load
);

    slot_state_t      state_q;
    slot_state_t      state_d;
    logic [REG_W-1:0] dst_q;
    logic             writes_reg;

    assign writes_reg = dec_wr && (dec_dst != '0);

    // next-state selection
    always_comb begin
        state_d = SLOT_BUBBLE;
        unique case ({advance, writes_reg, dec_load})
            3'b100, 3'b101: state_d = SLOT_NOWRITE;   // T_TAKE_QUIET
            3'b110:         state_d = SLOT_ALU;       // T_TAKE_ALU
            3'b111:         state_d = SLOT_LOAD;      // T_TAKE_LOAD
            default:        state_d = SLOT_BUBBLE;    // T_TAKE_BUBBLE
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_BUBBLE;
            dst_q   <= '0;
        end else begin
            state_q <= state_d;
            dst_q   <= advance ? dec_dst : '0;
        end
    end

    // outputs per state
    always_comb begin
        slot_live = 1'b0;
        slot_alu  = 1'b0;
        slot_load = 1'b0;
        unique case (state_q)
            SLOT_BUBBLE:  ;
            SLOT_NOWRITE: ;
            SLOT_ALU: begin
                slot_live = 1'b1;
                slot_alu  = 1'b1;
            end
            SLOT_LOAD: begin
                slot_live = 1'b1;
                slot_load = 1'b1;
            end
        endcase
    end

    assign slot_state = state_q;
    assign slot_dst   = dst_q;

endmodule

// File: rtl/hzd_src_match.sv
module hzd_src_match #(
    parameter int REG_W = 5
) (
    input  logic             dec_valid,
    input  logic [REG_W-1:0] src,
    input  logic             rd_en,
    input  logic [REG_W-1:0] slot_dst,
    input  logic             slot_live,
    output logic             dep
);

    logic src_nonzero;
    logic same_reg;

    assign src_nonzero = (src != '0);
    assign same_reg    = (src == slot_dst);
    assign dep         = dec_valid && rd_en && src_nonzero && same_reg && slot_live;

endmodule

// File: rtl/hzd_policy.sv
module hzd_policy #(
    parameter int NUM_FWD = 2
) (
    input  logic dep_a,
    input  logic dep_b,
    input  logic slot_alu,
    input  logic slot_load,
    input  logic br_taken,
    output logic stall,
    output logic can_fwd_a,
    output logic can_fwd_b
);

    logic load_use;
    logic unserved;

    assign load_use  = slot_load && (dep_a || dep_b);
    assign can_fwd_a = slot_alu && dep_a;

    generate
        if (NUM_FWD >= 2) begin : g_two_paths
            assign unserved  = 1'b0;
            assign can_fwd_b = slot_alu && dep_b;
        end else begin : g_one_path
            assign unserved  = slot_alu && dep_b;
            assign can_fwd_b = 1'b0;
        end
    endgenerate

    assign stall = (load_use || unserved) && !br_taken;

endmodule

// File: rtl/fwd_interlock.sv
module fwd_interlock
    import hzd_pkg::*;
#(
    parameter int REG_COUNT = 32,
    parameter int NUM_FWD   = 2,
    parameter int REG_W     = $clog2(REG_COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [REG_W-1:0] dec_src_a,
    input  logic             dec_rd_a,
    input  logic [REG_W-1:0] dec_src_b,
    input  logic             dec_rd_b,
    input  logic [REG_W-1:0] dec_dst,
    input  logic             dec_wr,
    input  logic             dec_load,
    input  logic             br_taken,
    output logic             fwd_a,
    output logic             fwd_b,
    output logic             stall,
    output logic             bubble,
    output logic             flush
);

    slot_state_t      slot_state;
    logic [REG_W-1:0] slot_dst;
    logic             slot_live;
    logic             slot_alu;
    logic             slot_load;
    logic             advance;
    logic             can_fwd_a;
    logic             can_fwd_b;
    logic             fwd_a_q;
    logic             fwd_b_q;

    logic [REG_W-1:0] src_vec [OPERANDS];
    logic             rd_vec  [OPERANDS];
    logic             dep_vec [OPERANDS];

    assign src_vec[OP_A] = dec_src_a;
    assign src_vec[OP_B] = dec_src_b;
    assign rd_vec[OP_A]  = dec_rd_a;
    assign rd_vec[OP_B]  = dec_rd_b;

    hzd_slot_fsm #(.REG_W(REG_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .dec_dst    (dec_dst),
        .dec_wr     (dec_wr),
        .dec_load   (dec_load),
        .slot_state (slot_state),
        .slot_dst   (slot_dst),
        .slot_live  (slot_live),
        .slot_alu   (slot_alu),
        .slot_load  (slot_load)
    );

    generate
        for (genvar g = 0; g < OPERANDS; g++) begin : g_match
            hzd_src_match #(.REG_W(REG_W)) u_match (
                .dec_valid (dec_valid),
                .src       (src_vec[g]),
                .rd_en     (rd_vec[g]),
                .slot_dst  (slot_dst),
                .slot_live (slot_live),
                .dep       (dep_vec[g])
            );
        end
    endgenerate

    hzd_policy #(.NUM_FWD(NUM_FWD)) u_policy (
        .dep_a     (dep_vec[OP_A]),
        .dep_b     (dep_vec[OP_B]),
        .slot_alu  (slot_alu),
        .slot_load (slot_load),
        .br_taken  (br_taken),
        .stall     (stall),
        .can_fwd_a (can_fwd_a),
        .can_fwd_b (can_fwd_b)
    );

    assign advance = dec_valid && !stall && !br_taken;
    assign bubble  = stall || br_taken;
    assign flush   = br_taken;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_a_q <= 1'b0;
            fwd_b_q <= 1'b0;
        end else begin
            fwd_a_q <= advance && can_fwd_a;
            fwd_b_q <= advance && can_fwd_b;
        end
    end

    assign fwd_a = fwd_a_q;
    assign fwd_b = fwd_b_q;

endmodule

// File: rtl/fwd_interlock_chk.sv
module fwd_interlock_chk #(
    parameter int NUM_FWD = 2,
    parameter int REG_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dec_valid,
    input logic [REG_W-1:0] dec_src_a,
    input logic [REG_W-1:0] dec_src_b,
    input logic             br_taken,
    input logic             fwd_a,
    input logic             fwd_b,
    input logic             stall,
    input logic             bubble
);

    p_stall_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    p_bubble_with_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> bubble);

    p_flush_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (!stall && bubble));

    p_flush_clears_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> (!fwd_a && !fwd_b));

    p_stall_no_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!fwd_a && !fwd_b));

    p_zero_never_fwd_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_a |-> ($past(dec_src_a) != '0));

    p_zero_never_fwd_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_b |-> ($past(dec_src_b) != '0));

    p_idle_no_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dec_valid) |-> (!fwd_a && !fwd_b));

    generate
        if (NUM_FWD < 2) begin : g_one_path_chk
            p_no_b_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
                dec_valid |=> !fwd_b);
        end
    endgenerate

endmodule

bind fwd_interlock fwd_interlock_chk #(.NUM_FWD(NUM_FWD), .REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_valid (dec_valid),
    .dec_src_a (dec_src_a),
    .dec_src_b (dec_src_b),
    .br_taken  (br_taken),
    .fwd_a     (fwd_a),
    .fwd_b     (fwd_b),
    .stall     (stall),
    .bubble    (bubble)
);

// File: tb/fwd_interlock_test.sv
module fwd_interlock_test;

    localparam int CLK_PERIOD = 10;
    localparam int REG_W      = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic             dv   [2];
    logic [REG_W-1:0] sa   [2];
    logic             ra   [2];
    logic [REG_W-1:0] sb   [2];
    logic             rb   [2];
    logic [REG_W-1:0] dd   [2];
    logic             dw   [2];
    logic             dl   [2];
    logic             bt   [2];
    logic             fa   [2];
    logic             fb   [2];
    logic             st   [2];
    logic             bu   [2];
    logic             fl   [2];

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // index 0: one bypass path, index 1: two bypass paths
    fwd_interlock #(.NUM_FWD(1)) uut_single (
        .clk(clk), .rst_n(rst_n), .dec_valid(dv[0]), .dec_src_a(sa[0]), .dec_rd_a(ra[0]),
        .dec_src_b(sb[0]), .dec_rd_b(rb[0]), .dec_dst(dd[0]), .dec_wr(dw[0]),
        .dec_load(dl[0]), .br_taken(bt[0]), .fwd_a(fa[0]), .fwd_b(fb[0]),
        .stall(st[0]), .bubble(bu[0]), .flush(fl[0])
    );

    fwd_interlock #(.NUM_FWD(2)) uut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dv[1]), .dec_src_a(sa[1]), .dec_rd_a(ra[1]),
        .dec_src_b(sb[1]), .dec_rd_b(rb[1]), .dec_dst(dd[1]), .dec_wr(dw[1]),
        .dec_load(dl[1]), .br_taken(bt[1]), .fwd_a(fa[1]), .fwd_b(fb[1]),
        .stall(st[1]), .bubble(bu[1]), .flush(fl[1])
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive_idle(input int k);
        dv[k] = 1'b0; sa[k] = '0; ra[k] = 1'b0; sb[k] = '0; rb[k] = 1'b0;
        dd[k] = '0; dw[k] = 1'b0; dl[k] = 1'b0; bt[k] = 1'b0;
    endtask

    task automatic drive_producer(input int k, input int pd, input bit pw, input bit pl);
        drive_idle(k);
        dv[k] = 1'b1; dd[k] = REG_W'(pd); dw[k] = pw; dl[k] = pl;
    endtask

    task automatic drive_consumer(input int k, input int a, input bit rda,
                                  input int b, input bit rdb);
        drive_idle(k);
        dv[k] = 1'b1; sa[k] = REG_W'(a); ra[k] = rda; sb[k] = REG_W'(b); rb[k] = rdb;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // one producer/consumer pair, starting and ending with an empty slot
    task automatic run_pair(input int k, input int pd, input bit pw, input bit pl,
                            input int a, input bit rda, input int b, input bit rdb);
        int  nf;
        bit  dep_a;
        bit  dep_b;
        int  exp_stall;
        bit  exp_fa;
        bit  exp_fb;
        int  cnt;
        string tag;
        nf    = (k == 0) ? 1 : 2;
        dep_a = pw && (pd != 0) && rda && (a == pd);
        dep_b = pw && (pd != 0) && rdb && (b == pd);
        if (!(dep_a || dep_b))  exp_stall = 0;
        else if (pl)            exp_stall = 1;
        else if (nf == 1 && dep_b) exp_stall = 1;
        else                    exp_stall = 0;
        exp_fa = dep_a && !pl && (exp_stall == 0);
        exp_fb = dep_b && !pl && (nf == 2);
        if (pd == 0 && pw && ((rda && a == 0) || (rdb && b == 0))) tag = "R2";
        else if (!(dep_a || dep_b)) tag = "R9";
        else if (pl)                tag = "R6";
        else if (nf == 2)           tag = "R3";
        else if (dep_b)             tag = "R5";
        else                        tag = "R4";

        @(negedge clk);
        drive_producer(k, pd, pw, pl);
        @(negedge clk);
        drive_consumer(k, a, rda, b, rdb);
        cnt = 0;
        for (int g = 0; g < 4; g++) begin
            #1;
            if (!st[k]) break;
            cnt++;
            if (!bu[k]) check("R7", "bubble during stall", 0, 1);
            @(negedge clk);
        end
        check(tag, $sformatf("stall cycles cfg=%0d", nf), cnt, exp_stall);
        @(negedge clk);
        drive_idle(k);
        #1;
        check(tag, $sformatf("fwd_a cfg=%0d", nf), int'(fa[k]), int'(exp_fa));
        check(tag, $sformatf("fwd_b cfg=%0d", nf), int'(fb[k]), int'(exp_fb));
    endtask

    // taken branch while a dependent instruction sits in decode
    task automatic run_flush(input int k);
        @(negedge clk);
        drive_producer(k, 3, 1'b1, 1'b0);
        @(negedge clk);
        drive_consumer(k, 3, 1'b1, 3, 1'b1);
        bt[k] = 1'b1;
        #1;
        check("R8", "stall under flush", int'(st[k]), 0);
        check("R8", "flush", int'(fl[k]), 1);
        check("R8", "bubble under flush", int'(bu[k]), 1);
        @(negedge clk);
        drive_consumer(k, 3, 1'b1, 3, 1'b1);
        #1;
        check("R8", "fwd_a after flush", int'(fa[k]), 0);
        check("R8", "fwd_b after flush", int'(fb[k]), 0);
        check("R8", "slot empty after flush", int'(st[k]), 0);
        @(negedge clk);
        drive_idle(k);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            check("WATCHDOG", "run completed", 0, 1);
            finish_run();
        end
    end

    initial begin
        for (int k = 0; k < 2; k++) drive_idle(k);
        repeat (3) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            #1;
            check("R1", "fwd_a in reset", int'(fa[k]), 0);
            check("R1", "fwd_b in reset", int'(fb[k]), 0);
            check("R1", "stall in reset", int'(st[k]), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 2; k++) begin
            drive_consumer(k, 1, 1'b1, 1, 1'b1);
            #1;
            check("R1", "no stall from empty slot", int'(st[k]), 0);
        end
        @(negedge clk);
        for (int k = 0; k < 2; k++) drive_idle(k);
        #1;
        for (int k = 0; k < 2; k++) begin
            check("R1", "fwd_a after reset", int'(fa[k]), 0);
            check("R1", "fwd_b after reset", int'(fb[k]), 0);
        end

        for (int k = 0; k < 2; k++) begin
            for (int pd = 0; pd < 4; pd++)
                for (int pw = 0; pw < 2; pw++)
                    for (int pl = 0; pl < 2; pl++)
                        for (int a = 0; a < 4; a++)
                            for (int rda = 0; rda < 2; rda++)
                                for (int b = 0; b < 4; b++)
                                    for (int rdb = 0; rdb < 2; rdb++)
                                        run_pair(k, pd, pw[0], pl[0], a, rda[0], b, rdb[0]);
            run_flush(k);
        end

        done = 1'b1;
        finish_run();
    end

endmodule